// File: doc/BRIEF.md
# Descriptor Command List Processor

This block is the command-side sequencer of a DMA network controller. An attention pulse makes it fetch a 16-bit command word from a control block in memory. It clears that word and applies the control codes it carries to the command-unit and receive-unit states. It then walks a singly linked chain of command blocks in memory. Every memory access goes through a single-outstanding request interface with 16-bit and 32-bit transfers.

For each block it:
- marks the block busy;
- reads the block's opcode word;
- hands non-zero opcodes to an external executor through a request/done handshake;
- writes the completion status;
- follows the link.

Flag bits in each block decide whether the chain ends, whether the unit parks in the suspended state, and whether an interrupt is raised. After every update the block writes a packed status word, carrying event flags and both unit states, back to the control block. That word is also shown continuously on an output port.

Top module: `cmd_list_unit`

## Requirements
- R1: After reset the status word is 0x0010 (CU idle=0 in bits 10:8, RU suspended=1 in bits 6:4, no events), `irq` is low, `busy` is low and no memory or executor request is raised.
- R2: On attention the block reads the 16-bit command word at control+2 and then writes zero there. Any of event bits 15:12 (CX=15, FR=14, CNA=13, RNR=12) that are set in the command word are cleared.
- R3: Command-word bits 10:8 select the CU action. Code 1 makes the CU active (2). Code 4 makes it suspended (1) and sets CNA. Every other code leaves the CU unchanged.
- R4: Command-word bits 6:4 select the RU action. Codes 1 and 2 make the RU idle (0). Codes 3 and 4 make it suspended (1) and set RNR. Other codes are ignored.
- R5: The status word is {events[15:12], 0, CU[10:8], 0, RU[6:4], 4'b0}. It is written as a 16-bit value to control+0 once after the command word is handled, and once after every block.
- R6: A 32-bit read of control+4 loads the list pointer only when the CU is not suspended and the held pointer is null (all ones).
- R7: For each block at address P the accesses are, in order: 16-bit write 0x4000 to P, 16-bit read of P+2, 16-bit write 0xA000 to P, 32-bit read of P+4. A 32-bit read returns the word at address+2 in bits 31:16.
- R8: The opcode is bits 2:0 of the word at P+2. A non-zero opcode raises `execReq` with `execOp` and `execBlk`=P, held stable until `execDone`. Opcode 0 performs no handshake.
- R9: A link of zero or all ones, or block bit 15 (end of list), makes the pointer null and ends the walk.
- R10: Block bit 14 suspends the CU after that block and stops the walk. The pointer keeps the link, so a later CU start resumes from it without reloading from control+4.
- R11: Block bit 13 sets CX and raises `irq` when that block's status word is written; without bit 13, CX is cleared. `irq` stays high until `irqClear`.
- R12: The walk stops after any block that leaves the CU in a state other than active.
- R13: Command-word bit 7 is a soft reset, applied after the CU and RU codes of the same word. It sets the CU idle, the RU suspended, the pointer null and the events to zero.
- R14: An attention that arrives while the block is busy is remembered and served after the current pass. Each memory request is held with stable address and direction until `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attn | input | 1 | Attention pulse; starts a pass |
| scbAddr | input | ADDR_W | Byte address of the control block |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWrite | output | 1 | 1 = write, 0 = read |
| memWide | output | 1 | 1 = 32-bit transfer, 0 = 16-bit |
| memAddr | output | ADDR_W | Byte address of the access |
| memWdata | output | 32 | Write data (16-bit writes use bits 15:0) |
| memAck | input | 1 | One-cycle acknowledge; read data valid with it |
| memRdata | input | 32 | Read data |
| execReq | output | 1 | Executor request for the current block |
| execOp | output | 3 | Opcode of the current block |
| execBlk | output | ADDR_W | Address of the current block |
| execDone | input | 1 | Executor completion |
| irq | output | 1 | Interrupt request level |
| irqClear | input | 1 | Clears `irq` |
| statusWord | output | 16 | Current packed status word |
| busy | output | 1 | A pass is in progress |

## Verification
On every cycle the assertions check that:
- a memory or executor request stays stable until its acknowledge;
- the two kinds of request never overlap, and the executor is never asked to run opcode 0;
- the interrupt level holds until cleared;
- the status word only ever carries legal unit-state encodings with zero reserved bits;
- no request is raised while idle.

The order and content of the accesses can only be shown by the bench's scenarios, which compare every transaction against a behavioural reference that walks the same list. These scenarios cover the CU and RU code decoding, acknowledge clearing, suspend and resume from a held pointer, soft-reset priority, the three ways a list ends, and queued attention.

// File: rtl/cmd_list_pkg.sv
package cmd_list_pkg;

  localparam logic [2:0] CU_IDLE = 3'd0;
  localparam logic [2:0] CU_SUSP = 3'd1;
  localparam logic [2:0] CU_ACT  = 3'd2;
  localparam logic [2:0] RU_IDLE = 3'd0;
  localparam logic [2:0] RU_SUSP = 3'd1;

  localparam logic [15:0] MARK_BUSY_VAL = 16'h4000;
  localparam logic [15:0] MARK_DONE_VAL = 16'hA000;

  // Event flag positions inside the 4-bit event field
  localparam int EV_CX  = 3;
  localparam int EV_CNA = 1;
  localparam int EV_RNR = 0;

  // Block command word flag bits
  localparam int BLK_LAST = 15;
  localparam int BLK_PARK = 14;
  localparam int BLK_INTR = 13;

  typedef enum logic [3:0] {
    ACC_NONE, ACC_RD_CTL, ACC_CLR_CTL, ACC_RD_HEAD, ACC_WR_STAT,
    ACC_MARK_BUSY, ACC_RD_OP, ACC_MARK_DONE, ACC_RD_LINK
  } acc_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTL, S_CLR_CTL, S_RD_HEAD, S_WR_STAT0,
    S_BUSY, S_RD_OP, S_EXEC, S_DONE, S_RD_LINK, S_WR_STAT1
  } state_e;

  typedef struct packed {
    acc_e acc;
    logic takeCtl;
    logic takeHead;
    logic takeOp;
    logic takeLink;
    logic raiseIrq;
  } strobe_t;

endpackage

// File: rtl/cmd_list_ctrl.sv
module cmd_list_ctrl
  import cmd_list_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    attn,
  input  logic    memAck,
  input  logic    execDone,
  input  logic    ptrNull,
  input  logic    cuSusp,
  input  logic    cuActive,
  input  logic    opZero,
  input  logic    intrFlag,
  output strobe_t stb,
  output logic    execReq,
  output logic    busy
);

  state_e state, nxt;
  logic   attnPend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      attnPend <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && (attn || attnPend)) attnPend <= 1'b0;
      else if (attn)                             attnPend <= 1'b1;
    end
  end

  always_comb begin
    nxt          = state;
    stb.acc      = ACC_NONE;
    stb.takeCtl  = 1'b0;
    stb.takeHead = 1'b0;
    stb.takeOp   = 1'b0;
    stb.takeLink = 1'b0;
    stb.raiseIrq = 1'b0;
    unique case (state)
      S_IDLE:     if (attn || attnPend) nxt = S_RD_CTL;
      S_RD_CTL: begin
        stb.acc = ACC_RD_CTL;
        if (memAck) begin stb.takeCtl = 1'b1; nxt = S_CLR_CTL; end
      end
      S_CLR_CTL: begin
        stb.acc = ACC_CLR_CTL;
        if (memAck) nxt = (!cuSusp && ptrNull) ? S_RD_HEAD : S_WR_STAT0;
      end
      S_RD_HEAD: begin
        stb.acc = ACC_RD_HEAD;
        if (memAck) begin stb.takeHead = 1'b1; nxt = S_WR_STAT0; end
      end
      S_WR_STAT0: begin
        stb.acc = ACC_WR_STAT;
        if (memAck) nxt = ptrNull ? S_IDLE : S_BUSY;
      end
      S_BUSY: begin
        stb.acc = ACC_MARK_BUSY;
        if (memAck) nxt = S_RD_OP;
      end
      S_RD_OP: begin
        stb.acc = ACC_RD_OP;
        if (memAck) begin stb.takeOp = 1'b1; nxt = S_EXEC; end
      end
      S_EXEC:     if (opZero || execDone) nxt = S_DONE;
      S_DONE: begin
        stb.acc = ACC_MARK_DONE;
        if (memAck) nxt = S_RD_LINK;
      end
      S_RD_LINK: begin
        stb.acc = ACC_RD_LINK;
        if (memAck) begin stb.takeLink = 1'b1; nxt = S_WR_STAT1; end
      end
      S_WR_STAT1: begin
        stb.acc = ACC_WR_STAT;
        if (memAck) begin
          stb.raiseIrq = intrFlag;
          nxt = (cuActive && !ptrNull) ? S_BUSY : S_IDLE;
        end
      end
      default:    nxt = S_IDLE;
    endcase
  end

  assign execReq = (state == S_EXEC) && !opZero;
  assign busy    = (state != S_IDLE);

endmodule

// File: rtl/cmd_list_dp.sv
module cmd_list_dp
  import cmd_list_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [31:0]       memRdata,
  input  logic              irqClear,
  input  logic [ADDR_W-1:0] scbAddr,
  output logic              memReq,
  output logic              memWrite,
  output logic              memWide,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [15:0]       statusWord,
  output logic              irq,
  output logic [2:0]        execOp,
  output logic [ADDR_W-1:0] execBlk,
  output logic              ptrNull,
  output logic              cuSusp,
  output logic              cuActive,
  output logic              opZero,
  output logic              intrFlag
);

  localparam logic [ADDR_W-1:0] NULL_PTR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_LINK = ADDR_W'(4);

  logic [2:0]        cuSt, ruSt, nCu, nRu;
  logic [3:0]        ev, nEv;
  logic [ADDR_W-1:0] ptr, nPtr, linkVal;
  logic [15:0]       blkCmd, ctlWord;

  assign ctlWord = memRdata[15:0];
  assign linkVal = memRdata[ADDR_W-1:0];

  // Apply the control-word codes to the unit states and events
  always_comb begin
    nEv  = ev & ~ctlWord[15:12];
    nCu  = cuSt;
    nRu  = ruSt;
    nPtr = ptr;
    case (ctlWord[10:8])
      3'd1: nCu = CU_ACT;
      3'd4: begin nCu = CU_SUSP; nEv[EV_CNA] = 1'b1; end
      default: ;
    endcase
    case (ctlWord[6:4])
      3'd1, 3'd2: nRu = RU_IDLE;
      3'd3, 3'd4: begin nRu = RU_SUSP; nEv[EV_RNR] = 1'b1; end
      default: ;
    endcase
    if (ctlWord[7]) begin
      nCu  = CU_IDLE;
      nRu  = RU_SUSP;
      nPtr = NULL_PTR;
      nEv  = 4'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cuSt   <= CU_IDLE;
      ruSt   <= RU_SUSP;
      ev     <= 4'd0;
      ptr    <= NULL_PTR;
      blkCmd <= 16'd0;
      irq    <= 1'b0;
    end else begin
      if (stb.takeCtl) begin
        cuSt <= nCu;
        ruSt <= nRu;
        ev   <= nEv;
        ptr  <= nPtr;
      end
      if (stb.takeHead) ptr <= linkVal;
      if (stb.takeOp)   blkCmd <= memRdata[15:0];
      if (stb.takeLink) begin
        if (linkVal == '0 || linkVal == NULL_PTR || blkCmd[BLK_LAST]) ptr <= NULL_PTR;
        else                                                          ptr <= linkVal;
        if (blkCmd[BLK_PARK]) cuSt <= CU_SUSP;
        ev[EV_CX] <= blkCmd[BLK_INTR];
      end
      if (stb.raiseIrq)  irq <= 1'b1;
      else if (irqClear) irq <= 1'b0;
    end
  end

  assign statusWord = {ev, 1'b0, cuSt, 1'b0, ruSt, 4'b0000};

  // Access steering
  always_comb begin
    memReq   = (stb.acc != ACC_NONE);
    memWrite = 1'b0;
    memWide  = 1'b0;
    memAddr  = scbAddr;
    memWdata = 32'd0;
    unique case (stb.acc)
      ACC_RD_CTL:    memAddr = scbAddr + OFS_CMD;
      ACC_CLR_CTL: begin memAddr = scbAddr + OFS_CMD; memWrite = 1'b1; end
      ACC_RD_HEAD: begin memAddr = scbAddr + OFS_LINK; memWide = 1'b1; end
      ACC_WR_STAT: begin memWrite = 1'b1; memWdata = {16'd0, statusWord}; end
      ACC_MARK_BUSY: begin memAddr = ptr; memWrite = 1'b1; memWdata = {16'd0, MARK_BUSY_VAL}; end
      ACC_RD_OP:     memAddr = ptr + OFS_CMD;
      ACC_MARK_DONE: begin memAddr = ptr; memWrite = 1'b1; memWdata = {16'd0, MARK_DONE_VAL}; end
      ACC_RD_LINK: begin memAddr = ptr + OFS_LINK; memWide = 1'b1; end
      default: ;
    endcase
  end

  assign execOp   = blkCmd[2:0];
  assign execBlk  = ptr;
  assign ptrNull  = (ptr == NULL_PTR);
  assign cuSusp   = (cuSt == CU_SUSP);
  assign cuActive = (cuSt == CU_ACT);
  assign opZero   = (blkCmd[2:0] == 3'd0);
  assign intrFlag = blkCmd[BLK_INTR];

endmodule

// File: rtl/cmd_list_unit.sv
module cmd_list_unit
  import cmd_list_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              attn,
  input  logic [ADDR_W-1:0] scbAddr,
  output logic              memReq,
  output logic              memWrite,
  output logic              memWide,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic              execReq,
  output logic [2:0]        execOp,
  output logic [ADDR_W-1:0] execBlk,
  input  logic              execDone,
  output logic              irq,
  input  logic              irqClear,
  output logic [15:0]       statusWord,
  output logic              busy
);

  strobe_t stb;
  logic    ptrNull, cuSusp, cuActive, opZero, intrFlag;

  cmd_list_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .attn(attn), .memAck(memAck), .execDone(execDone),
    .ptrNull(ptrNull), .cuSusp(cuSusp), .cuActive(cuActive), .opZero(opZero),
    .intrFlag(intrFlag), .stb(stb), .execReq(execReq), .busy(busy)
  );

  cmd_list_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .memRdata(memRdata), .irqClear(irqClear),
    .scbAddr(scbAddr), .memReq(memReq), .memWrite(memWrite), .memWide(memWide),
    .memAddr(memAddr), .memWdata(memWdata), .statusWord(statusWord), .irq(irq),
    .execOp(execOp), .execBlk(execBlk), .ptrNull(ptrNull), .cuSusp(cuSusp),
    .cuActive(cuActive), .opZero(opZero), .intrFlag(intrFlag)
  );

endmodule

// File: rtl/cmd_list_chk.sv
module cmd_list_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              memReq,
  input logic              memWrite,
  input logic              memWide,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic              execReq,
  input logic [2:0]        execOp,
  input logic [ADDR_W-1:0] execBlk,
  input logic              execDone,
  input logic              irq,
  input logic              irqClear,
  input logic [15:0]       statusWord,
  input logic              busy
);

  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWrite) && $stable(memWide)); // R14

  AST_EXEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    execReq && !execDone |=> execReq && $stable(execOp) && $stable(execBlk)); // R8

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(memReq && execReq)); // R8

  AST_EXEC_NONZERO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    execReq |-> execOp != 3'd0); // R8

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irqClear |=> irq); // R11

  AST_STATUS_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
    statusWord[11] == 1'b0 && statusWord[7] == 1'b0 && statusWord[3:0] == 4'd0
    && statusWord[10:8] <= 3'd2); // R5

  AST_RU_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
    statusWord[6:4] == 3'd0 || statusWord[6:4] == 3'd1 || statusWord[6:4] == 3'd4); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !memReq && !execReq); // R14

endmodule

bind cmd_list_unit cmd_list_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_cmd_list_unit.sv
module sim_cmd_list_unit;

  localparam int SCB = 'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        attn = 1'b0;
  logic [31:0] scbAddr = SCB;
  logic        memReq, memWrite, memWide;
  logic [31:0] memAddr, memWdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = 32'd0;
  logic        execReq;
  logic [2:0]  execOp;
  logic [31:0] execBlk;
  logic        execDone = 1'b0;
  logic        irq;
  logic        irqClear = 1'b0;
  logic [15:0] statusWord;
  logic        busy;

  always #5 clk = ~clk;

  cmd_list_unit u0 (.*);

  int nChk = 0, nFail = 0;
  int memLat = 0, execLat = 0;

  logic [15:0] mem [256];
  logic [15:0] pm  [256];

  // Expected transaction queue: kind 0 rd16, 1 wr16, 2 rd32, 3 exec
  int          qKind[$];
  logic [31:0] qAddr[$];
  logic [15:0] qData[$];
  string       qTag[$];

  // Reference state
  logic [2:0]  mCu = 3'd0, mRu = 3'd1;
  logic [3:0]  mEv = 4'd0;
  logic [31:0] mPtr = 32'hFFFF_FFFF;
  logic        mIrq = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ix(input logic [31:0] a);
    return a[8:1];
  endfunction

  function automatic logic [15:0] sw();
    return {mEv, 1'b0, mCu, 1'b0, mRu, 4'b0000};
  endfunction

  function automatic logic [31:0] p32(input logic [31:0] a);
    return {pm[ix(a + 2)], pm[ix(a)]};
  endfunction

  task automatic push(input int k, input logic [31:0] a, input logic [15:0] d, input string t);
    qKind.push_back(k); qAddr.push_back(a); qData.push_back(d); qTag.push_back(t);
  endtask

  // Behavioural reference for one attention pass, run on the model copy pm
  task automatic predict();
    logic [15:0] c, b;
    logic [31:0] nx;
    c = pm[ix(SCB + 2)];
    push(0, SCB + 2, 16'h0, "R2");
    pm[ix(SCB + 2)] = 16'h0;
    push(1, SCB + 2, 16'h0, "R2");
    mEv = mEv & ~c[15:12];
    if (c[10:8] == 3'd1) mCu = 3'd2;
    else if (c[10:8] == 3'd4) begin mCu = 3'd1; mEv[1] = 1'b1; end
    if (c[6:4] == 3'd1 || c[6:4] == 3'd2) mRu = 3'd0;
    else if (c[6:4] == 3'd3 || c[6:4] == 3'd4) begin mRu = 3'd1; mEv[0] = 1'b1; end
    if (c[7]) begin mCu = 3'd0; mRu = 3'd1; mPtr = 32'hFFFF_FFFF; mEv = 4'd0; end
    if (mCu != 3'd1 && mPtr == 32'hFFFF_FFFF) begin
      push(2, SCB + 4, 16'h0, "R6");
      mPtr = p32(SCB + 4);
    end
    push(1, SCB, sw(), "R5");
    while (mPtr != 32'hFFFF_FFFF) begin
      push(1, mPtr, 16'h4000, "R7");
      pm[ix(mPtr)] = 16'h4000;
      b = pm[ix(mPtr + 2)];
      push(0, mPtr + 2, 16'h0, "R7");
      if (b[2:0] != 3'd0) push(3, mPtr, {13'd0, b[2:0]}, "R8");
      push(1, mPtr, 16'hA000, "R7");
      pm[ix(mPtr)] = 16'hA000;
      push(2, mPtr + 4, 16'h0, "R9");
      nx = p32(mPtr + 4);
      if (nx == 32'd0 || nx == 32'hFFFF_FFFF || b[15]) mPtr = 32'hFFFF_FFFF;
      else mPtr = nx;
      if (b[14]) mCu = 3'd1;
      if (b[13]) begin mEv[3] = 1'b1; mIrq = 1'b1; end
      else mEv[3] = 1'b0;
      push(1, SCB, sw(), "R11");
      if (mCu != 3'd2) break;
    end
  endtask

  // Compare one observed transaction against the head of the queue
  task automatic observe(input int k, input logic [31:0] a, input logic [15:0] d);
    int ek; logic [31:0] ea; logic [15:0] ed; string t;
    if (qKind.size() == 0) begin
      chk(1'b0, "R7", "unexpected transaction", a, 0);
      return;
    end
    ek = qKind.pop_front(); ea = qAddr.pop_front(); ed = qData.pop_front(); t = qTag.pop_front();
    chk(k == ek, t, "transaction kind", k, ek);
    chk(a == ea, t, "transaction address", a, ea);
    if (k == 1 || k == 3) chk(d == ed, t, "transaction data", d, ed);
  endtask

  // Memory responder
  initial begin
    int w = 0;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (w < memLat) w++;
        else begin
          w = 0;
          if (memWrite) begin
            observe(1, memAddr, memWdata[15:0]);
            mem[ix(memAddr)] = memWdata[15:0];
          end else begin
            observe(memWide ? 2 : 0, memAddr, 16'h0);
            memRdata = memWide ? {mem[ix(memAddr + 2)], mem[ix(memAddr)]}
                               : {16'h0, mem[ix(memAddr)]};
          end
          memAck = 1'b1;
        end
      end
    end
  end

  // Executor responder
  initial begin
    int w = 0;
    forever begin
      @(negedge clk);
      if (execDone) execDone = 1'b0;
      else if (execReq) begin
        if (w < execLat) w++;
        else begin
          w = 0;
          observe(3, execBlk, {13'd0, execOp});
          execDone = 1'b1;
        end
      end
    end
  end

  task automatic setBlk(input logic [31:0] a, input logic [15:0] c, input logic [31:0] link);
    mem[ix(a)] = 16'h0; mem[ix(a + 2)] = c;
    mem[ix(a + 4)] = link[15:0]; mem[ix(a + 6)] = link[31:16];
  endtask

  task automatic setCtl(input logic [15:0] c, input logic [31:0] head);
    mem[ix(SCB + 2)] = c;
    mem[ix(SCB + 4)] = head[15:0]; mem[ix(SCB + 6)] = head[31:16];
  endtask

  task automatic snap();
    for (int i = 0; i < 256; i++) pm[i] = mem[i];
  endtask

  task automatic pulse();
    @(negedge clk); attn = 1'b1;
    @(negedge clk); attn = 1'b0;
  endtask

  task automatic waitIdle();
    int q = 0;
    while (q < 3) begin
      @(negedge clk);
      q = busy ? 0 : q + 1;
    end
  endtask

  task automatic verify(input string tagSt, input string tagQ);
    chk(qKind.size() == 0, tagQ, "pending expected transactions", qKind.size(), 0);
    qKind.delete(); qAddr.delete(); qData.delete(); qTag.delete();
    chk(statusWord == sw(), tagSt, "status word", statusWord, sw());
    chk(irq == mIrq, "R11", "irq level", irq, mIrq);
  endtask

  task automatic run(input string tagSt, input string tagQ);
    snap(); predict(); pulse(); waitIdle(); verify(tagSt, tagQ);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(statusWord == 16'h0010, "R1", "reset status", statusWord, 16'h0010);
    chk(!irq && !busy, "R1", "reset irq/busy", {irq, busy}, 0);
    chk(!memReq && !execReq, "R1", "reset requests", {memReq, execReq}, 0);

    // CU start, three-block list: nop, transmit with interrupt, setup with end-of-list
    setBlk('h20, 16'h0000, 'h40);
    setBlk('h40, 16'h2004, 'h60);
    setBlk('h60, 16'h8001, 'h80);
    setCtl(16'h0100, 'h20);
    memLat = 0; execLat = 1;
    run("R3", "R8");
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R11", "irq held", irq, 1);
    irqClear = 1'b1; @(negedge clk); irqClear = 1'b0; mIrq = 1'b0;
    chk(irq == 1'b0, "R11", "irq cleared", irq, 0);

    // Acknowledge of CX, reload head, all-ones link ends the list
    setBlk('hA0, 16'h0000, 32'hFFFF_FFFF);
    setCtl(16'h8000, 'hA0);
    memLat = 2;
    run("R2", "R9");

    // CU abort with RU start: no head load while suspended
    setCtl(16'h0410, 'hA0);
    memLat = 1;
    run("R3", "R6");

    // Unknown CU code 2 ignored, RU suspend sets RNR
    setCtl(16'h0230, 'hA0);
    run("R4", "R4");

    // Suspend bit parks the CU after the first block
    setBlk('h20, 16'h4002, 'h40);
    setBlk('h40, 16'h0005, 32'h0);
    setCtl(16'h0100, 'h20);
    execLat = 0;
    run("R10", "R10");
    chk(statusWord[10:8] == 3'd1, "R10", "CU suspended after park", statusWord[10:8], 1);

    // Start resumes from the held pointer; zero link ends the list
    setCtl(16'h0100, 'hA0);
    run("R10", "R9");

    // Soft reset overrides start; walk stops after one block since CU is idle
    setBlk('h20, 16'h0003, 'h40);
    setCtl(16'h0180, 'h20);
    run("R13", "R12");
    chk(statusWord == 16'h0010, "R13", "soft reset status", statusWord, 16'h0010);

    // Attention during a pass is served afterwards
    setCtl(16'h0100, 'hA0);
    memLat = 1;
    snap(); predict(); predict();
    pulse();
    repeat (3) @(negedge clk);
    pulse();
    waitIdle();
    verify("R14", "R14");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL R14 watchdog expired: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule